// File: doc/BRIEF.md
# Single-Cycle Word Processor Core

This block is a 32-bit processor core that completes one instruction per clock. Each clock edge it reads an instruction from a private instruction store, decodes it, reads two registers, runs the ALU and, when the instruction needs it, accesses a private data store. On the same edge it commits the result to the register file or to data memory and moves the program counter. It executes nine instructions: register-register add, subtract, AND, OR and signed set-on-less-than, word load, word store, branch-if-equal and an absolute jump.

Both stores are small word-addressed arrays inside the core. A loader port fills them while reset is held. After reset is released the core runs from address 0. Two debug outputs show its progress: the current program counter, and a registered report of each register write. The report gives the register index and the value written, and it appears in the cycle after the instruction that made the write.

Decoding happens in two levels. The main decoder turns the 6-bit opcode into datapath controls and a 2-bit operation class. The ALU decoder turns that class, plus the funct field for register-register instructions, into a 4-bit ALU code.

Top module: `rsc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0, every register is cleared to 0 and `wb_valid` is 0 in the following cycle.
- R2: For opcode 0, funct 0x20/0x22/0x24/0x25 write rs+rt, rs-rt, rs AND rt and rs OR rt (32-bit, wrapping) to rd (bits 15:11). The fields are rs at bits 25:21 and rt at bits 20:16.
- R3: Opcode 0 with funct 0x2A writes 1 to rd when rs < rt as signed 32-bit numbers, and 0 otherwise.
- R4: Opcode 35 loads the data word at byte address rs + sign-extended bits 15:0 into rt. The word index is address bits [DMEM_AW+1:2].
- R5: Opcode 43 writes rt's value to the data word at rs + sign-extended offset. It reports no register write.
- R6: Opcode 4 branches when rs equals rt. Taken, the next PC is PC+4 + (sign-extended offset << 2). Not taken, it is PC+4. A branch reports no register write.
- R7: Opcode 2 sets the next PC to {PC[31:28], bits 25:0, 2'b00}.
- R8: Register 0 always reads as 0. Writes that target it are dropped and not reported.
- R9: Any opcode outside {0, 2, 4, 35, 43}, and opcode 0 with a funct outside the five listed, writes no register and no memory and advances the PC by 4.
- R10: Every instruction other than a taken branch or a jump advances the PC by 4. The write report shows the index and the value that instruction wrote.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Loader write strobe; use only while rst is high |
| prog_dmem | input | 1 | Loader target: 0 = instruction store, 1 = data store |
| prog_addr | input | LOAD_AW | Loader word index |
| prog_data | input | 32 | Loader data word |
| pc_o | output | 32 | Current program counter |
| wb_valid | output | 1 | A register write was committed on the last edge |
| wb_reg | output | 5 | Index of that register |
| wb_data | output | 32 | Value written |

## Verification
The hardest case to reach is a jump that has to carry PC bits 31:28 forward. The instruction store is tiny, so the PC never leaves its low range through straight-line code. The stimulus jumps to target 0x3FFFFFF, which aliases to the last instruction word. A branch placed there carries the PC past 0x0FFFFFFF, and a later jump must keep the resulting top nibble of 1. Store effects and dropped writes are not visible on the ports directly, so later loads and adds bring them out through the write report.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  localparam logic [5:0] OPC_RR  = 6'd0;
  localparam logic [5:0] OPC_JMP = 6'd2;
  localparam logic [5:0] OPC_BEQ = 6'd4;
  localparam logic [5:0] OPC_LW  = 6'd35;
  localparam logic [5:0] OPC_SW  = 6'd43;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [1:0] {
    CLS_MEM  = 2'b00,
    CLS_BR   = 2'b01,
    CLS_RR   = 2'b10,
    CLS_NONE = 2'b11
  } op_class_e;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111
  } alu_op_e;

  typedef struct packed {
    logic      reg_we;
    logic      dst_is_rd;
    logic      use_imm;
    logic      mem_to_reg;
    logic      mem_we;
    logic      branch;
    logic      jump;
    op_class_e cls;
  } ctrl_t;

endpackage

// File: rtl/rsc_main_dec.sv
module rsc_main_dec
  import rsc_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '{reg_we: 1'b0, dst_is_rd: 1'b0, use_imm: 1'b0, mem_to_reg: 1'b0,
             mem_we: 1'b0, branch: 1'b0, jump: 1'b0, cls: CLS_NONE};
    case (opcode)
      OPC_RR: begin
        ctrl.reg_we    = 1'b1;
        ctrl.dst_is_rd = 1'b1;
        ctrl.cls       = CLS_RR;
      end
      OPC_LW: begin
        ctrl.reg_we     = 1'b1;
        ctrl.use_imm    = 1'b1;
        ctrl.mem_to_reg = 1'b1;
        ctrl.cls        = CLS_MEM;
      end
      OPC_SW: begin
        ctrl.use_imm = 1'b1;
        ctrl.mem_we  = 1'b1;
        ctrl.cls     = CLS_MEM;
      end
      OPC_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.cls    = CLS_BR;
      end
      OPC_JMP: ctrl.jump = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/rsc_alu_dec.sv
module rsc_alu_dec
  import rsc_pkg::*;
(
  input  op_class_e  cls,
  input  logic [5:0] funct,
  output alu_op_e    alu_op,
  output logic       funct_ok
);

  always_comb begin
    alu_op   = ALU_ADD;
    funct_ok = 1'b1;
    case (cls)
      CLS_MEM: alu_op = ALU_ADD;
      CLS_BR:  alu_op = ALU_SUB;
      CLS_RR: begin
        case (funct)
          FN_ADD:  alu_op = ALU_ADD;
          FN_SUB:  alu_op = ALU_SUB;
          FN_AND:  alu_op = ALU_AND;
          FN_OR:   alu_op = ALU_OR;
          FN_SLT:  alu_op = ALU_SLT;
          default: funct_ok = 1'b0;
        endcase
      end
      default: alu_op = ALU_ADD;
    endcase
  end

endmodule

// File: rtl/rsc_alu.sv
module rsc_alu
  import rsc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_op_e         op,
  output logic [XLEN-1:0] y,
  output logic            zero
);

  always_comb begin
    case (op)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/rsc_regfile.sv
module rsc_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [AW-1:0]   wa,
  input  logic [XLEN-1:0] wd,
  input  logic [AW-1:0]   ra1,
  input  logic [AW-1:0]   ra2,
  output logic [XLEN-1:0] rd1,
  output logic [XLEN-1:0] rd2
);

  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && (wa != '0)) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

endmodule

// File: rtl/rsc_core.sv
module rsc_core
  import rsc_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6,
  parameter int LOAD_AW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               prog_we,
  input  logic               prog_dmem,
  input  logic [LOAD_AW-1:0] prog_addr,
  input  logic [31:0]        prog_data,
  output logic [31:0]        pc_o,
  output logic               wb_valid,
  output logic [4:0]         wb_reg,
  output logic [31:0]        wb_data
);

  localparam int IDEPTH = 1 << IMEM_AW;
  localparam int DDEPTH = 1 << DMEM_AW;
  localparam int NREG   = 32;
  localparam int RF_AW  = 5;

  logic [31:0]     imem [IDEPTH];
  logic [XLEN-1:0] dmem [DDEPTH];

  logic [31:0]      pc_q;
  logic [31:0]      instr;
  logic [RF_AW-1:0] rs_idx, rt_idx, rd_idx, wa;
  logic [XLEN-1:0]  rs_val, rt_val, imm_sx, alu_b, alu_y, dmem_rd, wd;
  logic [31:0]      pc_plus4, br_tgt, jmp_tgt, pc_next;
  logic             alu_zero, funct_ok, rf_we;
  ctrl_t            ctrl;
  alu_op_e          alu_op;

  // instruction store: loader writes, core reads asynchronously
  always_ff @(posedge clk) begin
    if (prog_we && !prog_dmem) imem[prog_addr[IMEM_AW-1:0]] <= prog_data;
  end

  assign instr  = imem[pc_q[IMEM_AW+1:2]];
  assign rs_idx = instr[25:21];
  assign rt_idx = instr[20:16];
  assign rd_idx = instr[15:11];
  assign imm_sx = {{(XLEN-16){instr[15]}}, instr[15:0]};

  rsc_main_dec u_main_dec (
    .opcode (instr[31:26]),
    .ctrl   (ctrl)
  );

  rsc_alu_dec u_alu_dec (
    .cls      (ctrl.cls),
    .funct    (instr[5:0]),
    .alu_op   (alu_op),
    .funct_ok (funct_ok)
  );

  assign rf_we = !rst && ctrl.reg_we && funct_ok;
  assign wa    = ctrl.dst_is_rd ? rd_idx : rt_idx;

  rsc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk (clk),
    .rst (rst),
    .we  (rf_we),
    .wa  (wa),
    .wd  (wd),
    .ra1 (rs_idx),
    .ra2 (rt_idx),
    .rd1 (rs_val),
    .rd2 (rt_val)
  );

  assign alu_b = ctrl.use_imm ? imm_sx : rt_val;

  rsc_alu #(.XLEN(XLEN)) u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .op   (alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // data store: one write port shared by loader and core
  always_ff @(posedge clk) begin
    if (prog_we && prog_dmem) dmem[prog_addr[DMEM_AW-1:0]] <= prog_data;
    else if (!rst && ctrl.mem_we) dmem[alu_y[DMEM_AW+1:2]] <= rt_val;
  end

  assign dmem_rd = dmem[alu_y[DMEM_AW+1:2]];
  assign wd      = ctrl.mem_to_reg ? dmem_rd : alu_y;

  // next-PC selection
  assign pc_plus4 = pc_q + 32'd4;
  assign br_tgt   = pc_plus4 + {imm_sx[29:0], 2'b00};
  assign jmp_tgt  = {pc_q[31:28], instr[25:0], 2'b00};

  always_comb begin
    if (ctrl.jump)                   pc_next = jmp_tgt;
    else if (ctrl.branch && alu_zero) pc_next = br_tgt;
    else                             pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= '0;
      wb_valid <= 1'b0;
      wb_reg   <= '0;
      wb_data  <= '0;
    end else begin
      pc_q     <= pc_next;
      wb_valid <= rf_we && (wa != '0);
      wb_reg   <= wa;
      wb_data  <= wd;
    end
  end

  assign pc_o = pc_q;

  logic unused_bits;
  assign unused_bits = ^{instr[10:6], pc_q[1:0], alu_y, prog_addr};

endmodule

// File: rtl/rsc_core_chk.sv
module rsc_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc_o,
  input logic        wb_valid,
  input logic [4:0]  wb_reg,
  input logic [31:0] instr,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val
);

  AST_RESET_PC: assert property (@(posedge clk) rst |=> (pc_o == 32'd0)); // R1
  AST_RESET_NO_WB: assert property (@(posedge clk) rst |=> !wb_valid); // R1
  AST_R0_NEVER_REPORTED: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> (wb_reg != 5'd0)); // R8
  AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] == 6'd43) |=> !wb_valid); // R5
  AST_BRANCH_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    ((instr[31:26] == 6'd4) && (rs_val != rt_val)) |=> (pc_o == $past(pc_o) + 32'd4)); // R6
  AST_JUMP_SPLICE: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] == 6'd2) |=> (pc_o == {$past(pc_o[31:28]), $past(instr[25:0]), 2'b00})); // R7
  AST_SEQ_PC: assert property (@(posedge clk) disable iff (rst)
    ((instr[31:26] != 6'd2) && (instr[31:26] != 6'd4)) |=> (pc_o == $past(pc_o) + 32'd4)); // R10

endmodule

bind rsc_core rsc_core_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .pc_o     (pc_o),
  .wb_valid (wb_valid),
  .wb_reg   (wb_reg),
  .instr    (instr),
  .rs_val   (rs_val),
  .rt_val   (rt_val)
);

// File: tb/tb_rsc_core.sv
module tb_rsc_core;

  localparam int CLK_PERIOD = 10;
  localparam int LOAD_AW    = 8;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               prog_we = 1'b0;
  logic               prog_dmem = 1'b0;
  logic [LOAD_AW-1:0] prog_addr = '0;
  logic [31:0]        prog_data = '0;
  logic [31:0]        pc_o;
  logic               wb_valid;
  logic [4:0]         wb_reg;
  logic [31:0]        wb_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rsc_core #(.LOAD_AW(LOAD_AW)) dut (
    .clk (clk), .rst (rst), .prog_we (prog_we), .prog_dmem (prog_dmem),
    .prog_addr (prog_addr), .prog_data (prog_data), .pc_o (pc_o),
    .wb_valid (wb_valid), .wb_reg (wb_reg), .wb_data (wb_data)
  );

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int fn);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
  endfunction
  function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
    return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] enc_j(int tgt);
    return {6'd2, tgt[25:0]};
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put(bit to_d, int addr, logic [31:0] val);
    prog_we = 1'b1; prog_dmem = to_d; prog_addr = addr[LOAD_AW-1:0]; prog_data = val;
    tick();
    prog_we = 1'b0;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // checks the write report of the instruction just executed (vld=0: none expected)
  task automatic check_step(string req, logic [31:0] exp_pc, bit vld, int reg_i, logic [31:0] val);
    check({req, " pc"}, pc_o, exp_pc);
    check({req, " wb_valid"}, {31'd0, wb_valid}, {31'd0, vld});
    if (vld) begin
      check({req, " wb_reg"}, {27'd0, wb_reg}, reg_i);
      check({req, " wb_data"}, wb_data, val);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    logic [31:0] vals [8];
    int          fns  [5];
    vals = '{32'd0, 32'd1, 32'hFFFFFFFF, 32'd5, 32'hFFFFFFF9, 32'h7FFFFFFF, 32'h80000000, 32'h12345678};
    fns  = '{32, 34, 36, 37, 42};

    @(negedge clk);
    tick();
    // R1: reset state
    check("R1 reset pc", pc_o, 32'd0);
    check("R1 reset wb_valid", {31'd0, wb_valid}, 32'd0);

    // R2/R3: sweep of every operand pair through every register-register op
    foreach (vals[i]) begin
      foreach (vals[j]) begin
        for (int f = 0; f < 5; f++) begin
          logic [31:0] a, b, e;
          a = vals[i]; b = vals[j];
          case (fns[f])
            32: e = a + b;
            34: e = a - b;
            36: e = a & b;
            37: e = a | b;
            default: e = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          endcase
          rst = 1'b1;
          put(1'b1, 0, a);
          put(1'b1, 1, b);
          put(1'b0, 0, enc_i(35, 0, 1, 0));
          put(1'b0, 1, enc_i(35, 0, 2, 4));
          put(1'b0, 2, enc_r(1, 2, 3, fns[f]));
          rst = 1'b0;
          tick(); tick(); tick();
          check((fns[f] == 42) ? "R3 slt" : "R2 alu", wb_data, e);
          check("R10 alu pc", pc_o, 32'd12);
        end
      end
    end

    // R4/R5/R8/R9: memory, register zero and undefined encodings
    rst = 1'b1;
    put(1'b1, 0, 32'h12345678);
    put(1'b1, 1, 32'd16);
    put(1'b1, 3, 32'hDEAD0000);
    put(1'b0, 0,  enc_i(35, 0, 1, 0));
    put(1'b0, 1,  enc_i(35, 0, 2, 4));
    put(1'b0, 2,  enc_i(35, 2, 3, -4));
    put(1'b0, 3,  enc_i(43, 2, 1, -4));
    put(1'b0, 4,  enc_i(35, 0, 4, 12));
    put(1'b0, 5,  enc_i(63, 1, 5, 0));
    put(1'b0, 6,  enc_i(8, 1, 6, 7));
    put(1'b0, 7,  enc_r(1, 1, 7, 33));
    put(1'b0, 8,  enc_r(1, 1, 0, 32));
    put(1'b0, 9,  enc_i(35, 0, 0, 0));
    put(1'b0, 10, enc_r(0, 2, 8, 32));
    put(1'b0, 11, enc_i(35, 0, 9, 12));
    rst = 1'b0;
    tick(); check_step("R4 lw base", 32'd4, 1, 1, 32'h12345678);
    tick(); check_step("R4 lw addr", 32'd8, 1, 2, 32'd16);
    tick(); check_step("R4 lw neg offset", 32'd12, 1, 3, 32'hDEAD0000);
    tick(); check_step("R5 sw no wb", 32'd16, 0, 0, 0);
    tick(); check_step("R5 sw stored", 32'd20, 1, 4, 32'h12345678);
    tick(); check_step("R9 bad opcode", 32'd24, 0, 0, 0);
    tick(); check_step("R9 bad opcode 8", 32'd28, 0, 0, 0);
    tick(); check_step("R9 bad funct", 32'd32, 0, 0, 0);
    tick(); check_step("R8 add to r0", 32'd36, 0, 0, 0);
    tick(); check_step("R8 lw to r0", 32'd40, 0, 0, 0);
    tick(); check_step("R8 r0 reads zero", 32'd44, 1, 8, 32'd16);
    tick(); check_step("R9 no store by bad op", 32'd48, 1, 9, 32'h12345678);

    // R6/R7: branches and jumps, including carry into PC[31:28]
    rst = 1'b1;
    put(1'b1, 0, 32'd5);
    put(1'b1, 1, 32'd9);
    put(1'b0, 0,  enc_i(35, 0, 1, 0));
    put(1'b0, 1,  enc_i(35, 0, 2, 4));
    put(1'b0, 2,  enc_i(4, 1, 2, 5));
    put(1'b0, 3,  enc_i(4, 1, 1, 3));
    put(1'b0, 7,  enc_j(12));
    put(1'b0, 12, enc_i(4, 0, 0, -8));
    put(1'b0, 5,  enc_j(26'h3FFFFFF));
    put(1'b0, 63, enc_i(4, 0, 0, 1));
    rst = 1'b0;
    tick(); check_step("R10 lw", 32'd4, 1, 1, 32'd5);
    tick(); check_step("R10 lw", 32'd8, 1, 2, 32'd9);
    tick(); check_step("R6 not taken", 32'd12, 0, 0, 0);
    tick(); check_step("R6 taken fwd", 32'd28, 0, 0, 0);
    tick(); check_step("R7 jump", 32'd48, 0, 0, 0);
    tick(); check_step("R6 taken back", 32'd20, 0, 0, 0);
    tick(); check_step("R7 jump far", 32'h0FFFFFFC, 0, 0, 0);
    tick(); check_step("R6 taken carry", 32'h10000004, 0, 0, 0);
    tick(); check_step("R10 high lw", 32'h10000008, 1, 2, 32'd9);
    tick(); check_step("R6 high not taken", 32'h1000000C, 0, 0, 0);
    tick(); check_step("R6 high taken", 32'h1000001C, 0, 0, 0);
    tick(); check_step("R7 keep top nibble", 32'h10000030, 0, 0, 0);

    // R1: reset clears registers that held 5 and 9
    rst = 1'b1;
    put(1'b0, 0, enc_r(1, 2, 3, 32));
    rst = 1'b0;
    tick(); check_step("R1 regs cleared", 32'd4, 1, 3, 32'd0);

    done = 1'b1;
    report();
  end

endmodule